// File: doc/BRIEF.md
# Serial Command Port with Status Handshake

This block is the serial slave control port of a caption decoder. A host clocks command bytes in on a data line, most significant bit first. During each byte, the port returns a status byte on its data-out line. Commands of one or two bytes are decoded and passed to the decoder core as strobes. The core hands read-back data to the port as one or two bytes. The host fetches them with dedicated read commands, once the status byte reports that data is waiting.

All pins are oversampled in the core clock domain through a synchronizer. The port has an enable pin and a mode pin. Enable low floats data out, freezes the byte framer and throws away a partial byte. Enable and mode both low request a reset of the surrounding decoder and clear the port's own queue and busy timer. After each accepted core command, the port stays not-ready for a number of core cycles set by an input. This gives the core time to act on the command.

Top module: `spi_cmd_port`

## Requirements
- R1: Each byte is eight bits, most significant first. Data in is taken on rising edges of the serial clock. Data out moves to its next bit on falling edges.
- R2: While enable is low, the data-out enable is low and serial clock and data-in activity produces no strobe and no framer progress.
- R3: While enable and mode are both low, the reset request is high. This condition also empties the read queue and ends any busy period. With mode high and enable low, the reset request stays low.
- R4: Enable going low, or enable rising, resynchronizes the framer. Bits of a partly shifted byte are discarded, and the next eight clocks form a fresh byte.
- R5: Unless read data is armed, every transferred byte returns the status byte. Its layout is bit 7 ready, bit 6 data-available and bit 5 two-bytes-queued, with bits 4..0 zero.
- R6: Between bytes, data out holds the first bit of the next outgoing byte. With no read armed, this is the ready bit.
- R7: Opcodes are decoded as follows. 0x00 is NOP and is ignored. 0x01 is READ1 and 0x02 is READ2. Any other opcode with bit 7 clear is a one-byte command and raises cmd_stb_o with cmd_op_o. An opcode with bit 7 set starts a two-byte command. Its second byte raises cmd_stb_o together with dat_stb_o, cmd_op_o and cmd_dat_o, whatever that byte's value.
- R8: A pulse on rd_load_i replaces the queue contents. It sets data-available and sets the two-bytes flag to rd_two_i. The first byte returned is rd_data_i[15:8] and the second is rd_data_i[7:0].
- R9: READ1 or READ2 takes effect only while data-available is set. The byte transfers that follow then return one or up to two queued bytes, limited to what is queued. Data-available clears when the last queued byte has been shifted out.
- R10: A new command byte is accepted only while ready is set. Each core command strobe drops ready for busy_len_i core cycles, and a byte that arrives while not ready gives no strobe. The second byte of a two-byte command and the READ and NOP opcodes are exempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| en_i | input | 1 | Port enable |
| mode_i | input | 1 | Mode select; with enable low, low requests reset |
| busy_len_i | input | BUSY_W | Not-ready length after each core command, in core cycles |
| rd_load_i | input | 1 | Load read-back data into the queue |
| rd_two_i | input | 1 | Loaded data holds two bytes |
| rd_data_i | input | 16 | Read-back bytes, first byte in the upper half |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| cmd_stb_o | output | 1 | Command strobe to core |
| dat_stb_o | output | 1 | Strobe carries a data byte |
| cmd_op_o | output | 8 | Command opcode |
| cmd_dat_o | output | 8 | Data byte of a two-byte command |
| rst_req_o | output | 1 | Reset request to the decoder |

## Verification
A framer that has lost bit alignment shows up at once. The next command decodes to a wrong opcode, and the status byte read back in the same transfer arrives rotated, so it reads as neither 0x80 nor 0x00. If the queue count or armed count is wrong, it shows within one or two byte transfers. Either a data byte comes back where a status byte was expected, or the reverse, or data-available stays set once the queue should be empty. A busy timer that is wrong shows as the idle level on data out one byte after a command. It also shows as a command byte that gets a strobe while ready should still be low.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_NOP = 8'h00;
  localparam logic [BYTE_W-1:0] OP_RD1 = 8'h01;
  localparam logic [BYTE_W-1:0] OP_RD2 = 8'h02;

  function automatic logic [BYTE_W-1:0] status_byte(logic rdy, logic avail, logic two);
    return {rdy, avail, two, 5'b0};
  endfunction

  function automatic logic is_two_byte(logic [BYTE_W-1:0] op);
    return op[BYTE_W-1];
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] prev_o
);
  logic [STAGES-1:0][N-1:0] pipe_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign q_o    = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/spi_byte_framer.sv
module spi_byte_framer
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic              sdo_o,
  output logic              start_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_in_q, sh_out_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      sh_in_q  <= '0;
      sh_out_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        bit_q    <= '0;
        sh_out_q <= load_i;
      end else if (rise_i) begin
        sh_in_q <= {sh_in_q[BYTE_W-2:0], sdi_i};
        bit_q   <= bit_q + CNT_W'(1);
        done_q  <= (bit_q == CNT_W'(BYTE_W-1));
      end else if (fall_i && bit_q != '0) begin
        sh_out_q <= {sh_out_q[BYTE_W-2:0], 1'b0};
      end else if (bit_q == '0) begin
        sh_out_q <= load_i;  // keep idle byte current between transfers
      end
    end
  end

  assign sdo_o   = sh_out_q[BYTE_W-1];
  assign start_o = rise_i && !clr_i && bit_q == '0;
  assign done_o  = done_q;
  assign rx_o    = sh_in_q;

  assert_frame_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(bit_q) == CNT_W'(BYTE_W-1)) && (bit_q == '0));
  assert_resync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (bit_q == '0) && !done_q);
endmodule

// File: rtl/spi_read_queue.sv
module spi_read_queue
  import spi_cmd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic                two_i,
  input  logic [2*BYTE_W-1:0] data_i,
  input  logic                xfer_start_i,
  input  logic                xfer_done_i,
  input  logic [1:0]          arm_req_i,
  output logic [BYTE_W-1:0]   head_o,
  output logic                avail_o,
  output logic                two_o,
  output logic                armed_o
);
  logic [BYTE_W-1:0] q0_q, q1_q;
  logic [1:0]        cnt_q, arm_q;
  logic              data_xfer_q;

  logic       pop;
  logic [1:0] cnt_pop, arm_pop, arm_nxt;
  logic [2:0] arm_sum;

  always_comb begin
    pop     = xfer_done_i && data_xfer_q;
    cnt_pop = cnt_q - {1'b0, pop};
    arm_pop = arm_q - {1'b0, pop};
    arm_sum = {1'b0, arm_pop} + {1'b0, arm_req_i};
    arm_nxt = arm_pop;
    if (xfer_done_i && arm_req_i != 2'd0 && cnt_pop != 2'd0)
      arm_nxt = (arm_sum > {1'b0, cnt_pop}) ? cnt_pop : arm_sum[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_q <= '0; q1_q <= '0;
      cnt_q <= '0; arm_q <= '0;
      data_xfer_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; arm_q <= '0;
      data_xfer_q <= 1'b0;
    end else if (load_i) begin
      q0_q  <= data_i[2*BYTE_W-1:BYTE_W];
      q1_q  <= data_i[BYTE_W-1:0];
      cnt_q <= two_i ? 2'd2 : 2'd1;
      arm_q <= '0;
      data_xfer_q <= 1'b0;
    end else begin
      if (xfer_start_i) data_xfer_q <= (arm_q != 2'd0);
      if (xfer_done_i) begin
        cnt_q <= cnt_pop;
        arm_q <= arm_nxt;
        if (pop) q0_q <= q1_q;
      end
    end
  end

  assign head_o  = q0_q;
  assign avail_o = cnt_q != 2'd0;
  assign two_o   = cnt_q == 2'd2;
  assign armed_o = arm_q != 2'd0;

  assert_arm_le_cnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q <= cnt_q) && (cnt_q <= 2'd2));
  assert_load_avail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> avail_o && (two_o == $past(two_i)));
  assert_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i && data_xfer_q && cnt_q == 2'd1 && !load_i && !clr_i |=> !avail_o);
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int BUSY_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                sdi_i,
  input  logic                en_i,
  input  logic                mode_i,
  input  logic [BUSY_W-1:0]   busy_len_i,
  input  logic                rd_load_i,
  input  logic                rd_two_i,
  input  logic [2*BYTE_W-1:0] rd_data_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                cmd_stb_o,
  output logic                dat_stb_o,
  output logic [BYTE_W-1:0]   cmd_op_o,
  output logic [BYTE_W-1:0]   cmd_dat_o,
  output logic                rst_req_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pin_s, pin_p;
  logic sck_s, sdi_s, en_s, mode_s, sck_p, en_p;
  logic rise, fall, en_rise, soft_rst, clr;

  spi_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni,
    .d_i   ({mode_i, en_i, sdi_i, sck_i}),
    .q_o   (pin_s),
    .prev_o(pin_p)
  );

  assign {mode_s, en_s, sdi_s, sck_s} = pin_s;
  assign sck_p    = pin_p[0];
  assign en_p     = pin_p[2];
  assign rise     = en_s && sck_s && !sck_p;
  assign fall     = en_s && !sck_s && sck_p;
  assign en_rise  = en_s && !en_p;
  assign soft_rst = !en_s && !mode_s;
  assign clr      = !en_s || en_rise;

  logic [BUSY_W-1:0] busy_q;
  logic              ready, pend_q;
  logic [BYTE_W-1:0] pend_op_q, rx, head, load_val;
  logic              start, done, avail, two, armed;
  logic [1:0]        arm_req;
  logic              cmd_stb_q, dat_stb_q;
  logic [BYTE_W-1:0] op_q, dat_q;

  assign ready    = busy_q == '0;
  assign load_val = armed ? head : status_byte(ready, avail, two);

  spi_byte_framer i_framer (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .rise_i (rise),
    .fall_i (fall),
    .sdi_i  (sdi_s),
    .load_i (load_val),
    .sdo_o  (sdo_o),
    .start_o(start),
    .done_o (done),
    .rx_o   (rx)
  );

  always_comb begin
    arm_req = 2'd0;
    if (done && en_s && !pend_q) begin
      if (rx == OP_RD1)      arm_req = 2'd1;
      else if (rx == OP_RD2) arm_req = 2'd2;
    end
  end

  spi_read_queue i_queue (
    .clk_i, .rst_ni,
    .clr_i       (soft_rst),
    .load_i      (rd_load_i),
    .two_i       (rd_two_i),
    .data_i      (rd_data_i),
    .xfer_start_i(start),
    .xfer_done_i (done && en_s),
    .arm_req_i   (arm_req),
    .head_o      (head),
    .avail_o     (avail),
    .two_o       (two),
    .armed_o     (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0; pend_q <= 1'b0; pend_op_q <= '0;
      cmd_stb_q <= 1'b0; dat_stb_q <= 1'b0; op_q <= '0; dat_q <= '0;
    end else begin
      cmd_stb_q <= 1'b0;
      dat_stb_q <= 1'b0;
      if (busy_q != '0) busy_q <= busy_q - BUSY_W'(1);
      if (soft_rst) begin
        pend_q <= 1'b0;
        busy_q <= '0;
      end else if (clr) begin
        pend_q <= 1'b0;
      end else if (done) begin
        if (pend_q) begin
          cmd_stb_q <= 1'b1; dat_stb_q <= 1'b1;
          op_q <= pend_op_q; dat_q <= rx;
          pend_q <= 1'b0;
          busy_q <= busy_len_i;
        end else if (rx != OP_NOP && rx != OP_RD1 && rx != OP_RD2 && ready) begin
          if (is_two_byte(rx)) begin
            pend_q    <= 1'b1;
            pend_op_q <= rx;
          end else begin
            cmd_stb_q <= 1'b1;
            op_q      <= rx;
            busy_q    <= busy_len_i;
          end
        end
      end
    end
  end

  assign sdo_oe_o  = en_s;
  assign cmd_stb_o = cmd_stb_q;
  assign dat_stb_o = dat_stb_q;
  assign cmd_op_o  = op_q;
  assign cmd_dat_o = dat_q;
  assign rst_req_o = soft_rst;

  assert_busy_after_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> ($past(busy_len_i) == '0) || !ready);
  assert_two_byte_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_stb_o |-> cmd_stb_o && is_two_byte(cmd_op_o));
  assert_one_byte_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o && !dat_stb_o |-> !is_two_byte(cmd_op_o) && cmd_op_o != OP_NOP
                                && cmd_op_o != OP_RD1 && cmd_op_o != OP_RD2);
  assert_quiet_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o && $past(!sdo_oe_o) |-> !cmd_stb_o);
  assert_soft_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> ready && !avail);
endmodule

// File: tb/test_spi_cmd_port.sv
module test_spi_cmd_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int BW    = 12;

  logic clk = 0, rst_ni = 0;
  logic sck = 0, sdi = 0, en = 0, mode = 1;
  logic [BW-1:0] busy_len = '0;
  logic rd_load = 0, rd_two = 0;
  logic [15:0] rd_data = '0;
  logic sdo, sdo_oe, cmd_stb, dat_stb, rst_req;
  logic [7:0] cmd_op, cmd_dat;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_port #(.BUSY_W(BW)) i_spi_cmd_port (
    .clk_i(clk), .rst_ni, .sck_i(sck), .sdi_i(sdi), .en_i(en), .mode_i(mode),
    .busy_len_i(busy_len), .rd_load_i(rd_load), .rd_two_i(rd_two), .rd_data_i(rd_data),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cmd_stb_o(cmd_stb), .dat_stb_o(dat_stb),
    .cmd_op_o(cmd_op), .cmd_dat_o(cmd_dat), .rst_req_o(rst_req)
  );

  int n_chk = 0, n_bad = 0, n_cmd = 0;
  logic [7:0] last_op = '0, last_dat = '0;
  logic last_dflag = 0;

  always @(posedge clk) if (cmd_stb) begin
    n_cmd      <= n_cmd + 1;
    last_op    <= cmd_op;
    last_dat   <= cmd_dat;
    last_dflag <= dat_stb;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = tx[i];
      idle(HALF);
      sck = 1;
      rx[i] = sdo;
      idle(HALF);
      sck = 0;
    end
    idle(10);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic load(input logic two, input logic [15:0] d);
    rd_two = two; rd_data = d; rd_load = 1;
    idle(1);
    rd_load = 0;
    idle(4);
  endtask

  // {tx, expected status returned, expected strobe count, expected last opcode}
  localparam logic [31:0] VEC [7] = '{
    32'h10_80_01_10,   // one-byte command
    32'h00_80_01_10,   // NOP ignored
    32'h7F_80_02_7F,
    32'h85_80_02_7F,   // first byte of two-byte command
    32'h3C_80_03_85,   // second byte
    32'h01_80_03_85,   // READ1 with nothing queued
    32'h55_80_04_55    // status, not data: READ1 had no effect
  };

  bit finished = 0;

  initial begin
    logic [7:0] rx;
    idle(5);
    rst_ni = 1;
    idle(6);
    chk("R2 oe low when disabled", sdo_oe, 0);
    chk("R3 no reset request with mode high", rst_req, 0);
    en = 1;
    idle(6);
    chk("R2 oe high when enabled", sdo_oe, 1);
    chk("R6 idle level shows ready", sdo, 1);

    for (int i = 0; i < 7; i++) begin
      xfer(VEC[i][31:24], rx);
      chk("R5 R1 status byte", rx, VEC[i][23:16]);
      chk("R7 R1 strobe count", n_cmd, VEC[i][15:8]);
      chk("R7 R1 last opcode", last_op, VEC[i][7:0]);
    end

    // R7: second byte 0x00 is data, not NOP
    xfer(8'hC1, rx);
    xfer(8'h00, rx);
    chk("R7 two-byte count", n_cmd, 5);
    chk("R7 two-byte op", last_op, 8'hC1);
    chk("R7 two-byte data flag", last_dflag, 1);
    chk("R7 two-byte data", last_dat, 8'h00);

    // R2: activity while disabled
    en = 0; sdi = 1;
    idle(6);
    for (int i = 0; i < 8; i++) begin
      sck = 1; idle(HALF); sck = 0; idle(HALF);
    end
    chk("R2 oe low during activity", sdo_oe, 0);
    en = 1;
    idle(6);
    xfer(8'h23, rx);
    chk("R2 no framer progress while disabled", last_op, 8'h23);
    chk("R2 strobe count", n_cmd, 6);

    // R4: partial byte discarded
    bits(8'hFF, 3, rx);
    en = 0; idle(6); en = 1; idle(6);
    xfer(8'h22, rx);
    chk("R4 resync opcode", last_op, 8'h22);
    chk("R4 resync count", n_cmd, 7);

    // R8 R9 read flow
    load(1, 16'hA53C);
    xfer(8'h00, rx);
    chk("R5 R8 status two queued", rx, 8'hE0);
    xfer(8'h01, rx);
    xfer(8'h00, rx);
    chk("R9 first byte", rx, 8'hA5);
    xfer(8'h00, rx);
    chk("R5 R9 one left", rx, 8'hC0);
    xfer(8'h01, rx);
    xfer(8'h00, rx);
    chk("R9 second byte", rx, 8'h3C);
    xfer(8'h00, rx);
    chk("R9 avail cleared", rx, 8'h80);
    load(0, 16'h5A00);
    xfer(8'h00, rx);
    chk("R8 status one queued", rx, 8'hC0);
    xfer(8'h02, rx);
    xfer(8'h00, rx);
    chk("R9 READ2 single byte", rx, 8'h5A);
    xfer(8'h00, rx);
    chk("R9 READ2 clamped", rx, 8'h80);
    chk("R7 reads give no strobe", n_cmd, 7);

    // R10 busy window
    busy_len = 12'd1000;
    xfer(8'h11, rx);
    chk("R10 accepted", n_cmd, 8);
    chk("R6 idle level ready low", sdo, 0);
    xfer(8'h12, rx);
    chk("R10 R5 status not ready", rx, 8'h00);
    chk("R10 rejected while busy", n_cmd, 8);
    busy_len = '0;
    idle(1100);
    chk("R10 R6 ready again", sdo, 1);
    xfer(8'h13, rx);
    chk("R10 accepted after busy", last_op, 8'h13);

    // R3 soft reset
    load(1, 16'h1234);
    en = 0; mode = 0;
    idle(6);
    chk("R3 reset request", rst_req, 1);
    mode = 1; en = 1;
    idle(6);
    chk("R3 reset request released", rst_req, 0);
    xfer(8'h00, rx);
    chk("R3 queue emptied", rx, 8'h80);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog all-R act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule